// File: doc/BRIEF.md
# Cache Request Dispatch Controller

This block sits on the request side of one slice of a memory-side cache. Incoming requests land in one of two small ingress FIFOs. When the split option is set, writes go to their own write FIFO and everything else goes to the main FIFO. The engine keeps exactly one request in a holding register. It presents that request to a same-cycle tag lookup port and then decides the request's fate from the lookup result.

A read that hits produces a reply. A write that hits retires silently. A miss is announced to an external miss-merge table. Only a miss the table does not report as merged is pushed into an internal miss FIFO, which feeds DRAM. Write misses are not allocated: they are forwarded with the header bytes stripped from their size.

A separate issue stage offers one command per cycle to the DRAM scheduler. It serves eviction writebacks ahead of queued misses, and it holds off completely while the scheduler reports full. Four saturating event counters record read hits, write hits, read misses and write misses.

Top module: `cache_req_dispatch`

## Requirements
- R1: When `cfg_split_wr` is 0, every request, read or write, enters the main FIFO, and requests are served in arrival order. When it is 1, requests with `in_write`=1 enter the write FIFO instead.
- R2: A free holding register loads from the main FIFO whenever that FIFO holds an entry. It loads from the write FIFO only when the main FIFO is empty.
- R3: A held read whose lookup hits drives `reply_valid` with its address and id, and retires in the cycle `reply_ready` is 1, incrementing `cnt_rd_hit`. While `reply_ready` is 0, the request stays held, the reply stays stable and nothing is counted.
- R4: A held write whose lookup hits retires in one cycle, with no reply and no DRAM command, and increments `cnt_wr_hit`.
- R5: A missing request retries in place while the miss FIFO is full: the lookup stays asserted with the same address, and no miss counter moves. Once space frees, it is accepted and `cnt_rd_miss` or `cnt_wr_miss` increments.
- R6: Each accepted miss asserts `mg_valid` for one cycle with its line address, which is the address with the low log2(LINE_BYTES) bits cleared. If `mg_merged` is 1, nothing is sent toward DRAM. Otherwise the request is queued for DRAM with its full address.
- R7: A write miss is sent to DRAM with `dram_write`=1, no reply, and `dram_size` equal to `in_size` minus RD_HDR (8) bytes. A read miss keeps its size.
- R8: While `dram_full` is 1, `dram_valid` and `wb_ready` stay 0. Otherwise a pending writeback (`wb_valid`) is issued first, with `dram_is_wb`=1 and `dram_write`=1. Queued misses are issued only when no writeback waits, oldest first.
- R9: With `cfg_ideal`=1, every lookup is treated as a hit regardless of `lk_hit`, so no miss reaches DRAM.
- R10: Reset clears all four counters and empties all queues (`in_ready`=1, `lk_valid`=0, `dram_valid`=0). The counters never decrease and stop at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split_wr | input | 1 | Send writes to the separate write FIFO |
| cfg_ideal | input | 1 | Treat every lookup as a hit |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Target ingress FIFO has room |
| in_addr | input | 32 | Request byte address |
| in_write | input | 1 | Request is a write |
| in_size | input | 8 | Request size in bytes |
| in_id | input | 6 | Request tag |
| lk_valid | output | 1 | Lookup of the held request |
| lk_addr | output | 32 | Lookup address |
| lk_write | output | 1 | Held request is a write |
| lk_hit | input | 1 | Same-cycle lookup result |
| reply_valid | output | 1 | Read-hit reply valid |
| reply_ready | input | 1 | Reply queue has room |
| reply_addr | output | 32 | Reply address |
| reply_id | output | 6 | Reply tag |
| mg_valid | output | 1 | Register an accepted miss with the merge table |
| mg_line | output | 32 | Line address of that miss |
| mg_merged | input | 1 | Same-cycle: a miss to this line is already in flight |
| wb_valid | input | 1 | Eviction writeback pending |
| wb_ready | output | 1 | Writeback issued this cycle |
| wb_addr | input | 32 | Writeback address |
| wb_size | input | 8 | Writeback size |
| dram_full | input | 1 | DRAM scheduler cannot accept |
| dram_valid | output | 1 | DRAM command issued this cycle |
| dram_addr | output | 32 | Command address |
| dram_write | output | 1 | Command is a write |
| dram_size | output | 8 | Command payload size |
| dram_id | output | 6 | Command tag (0 for writebacks) |
| dram_is_wb | output | 1 | Command is an eviction writeback |
| cnt_rd_hit | output | 32 | Read hit count |
| cnt_wr_hit | output | 32 | Write hit count |
| cnt_rd_miss | output | 32 | Read miss count |
| cnt_wr_miss | output | 32 | Write miss count |

## Verification
The assertions take four things for granted about the inputs:
- the lookup and merge answers for a held request do not change while it waits;
- the two configuration bits change only while the block is empty;
- a writeback offer is held with stable fields until `wb_ready` accepts it;
- ingress and reply traffic respect valid/ready.

The stimulus answers `lk_hit` and `mg_merged` as pure functions of address bits 8 and 9, so the answers stay fixed for any held address. It changes configuration only after the queues have drained, and it drops `wb_valid` only in the half cycle after its handshake.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SIZE_W = 8;
  localparam int unsigned ID_W   = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [SIZE_W-1:0] size;
    logic [ID_W-1:0]   id;
  } crd_req_t;

  localparam int unsigned REQ_W = $bits(crd_req_t);

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_RD_HIT,
    ACT_WR_HIT,
    ACT_MISS_SEND,
    ACT_MISS_MERGE
  } crd_act_e;
endpackage

// File: rtl/crd_fifo.sv
module crd_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem_q[rd_ptr_q];
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_wr) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_rd) rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_ptr_q] <= din;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
endmodule

// File: rtl/crd_ingress.sv
module crd_ingress
  import crd_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_split_wr,
  input  logic     in_valid,
  output logic     in_ready,
  input  crd_req_t in_req,
  output logic     src_valid,
  output crd_req_t src_req,
  input  logic     src_take
);
  localparam int unsigned LANES = 2;  // lane 0 main, lane 1 write

  logic [LANES-1:0] lane_push, lane_pop, lane_full, lane_empty;
  logic [REQ_W-1:0] lane_dout [LANES];
  logic             to_wr;

  assign to_wr    = cfg_split_wr & in_req.wr;
  assign in_ready = to_wr ? ~lane_full[1] : ~lane_full[0];

  assign lane_push[0] = in_valid & ~to_wr & ~lane_full[0];
  assign lane_push[1] = in_valid &  to_wr & ~lane_full[1];
  assign lane_pop[0]  = src_take & ~lane_empty[0];
  assign lane_pop[1]  = src_take &  lane_empty[0] & ~lane_empty[1];

  assign src_valid = ~lane_empty[0] | ~lane_empty[1];
  assign src_req   = crd_req_t'(~lane_empty[0] ? lane_dout[0] : lane_dout[1]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crd_fifo #(.WIDTH(REQ_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lane_push[g]),
      .din   (in_req),
      .full  (lane_full[g]),
      .pop   (lane_pop[g]),
      .dout  (lane_dout[g]),
      .empty (lane_empty[g])
    );
  end
endmodule

// File: rtl/crd_req_engine.sv
module crd_req_engine
  import crd_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned RD_HDR     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ideal,
  input  logic              src_valid,
  input  crd_req_t          src_req,
  output logic              src_take,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              lk_write,
  input  logic              lk_hit,
  output logic              reply_valid,
  input  logic              reply_ready,
  output logic [ADDR_W-1:0] reply_addr,
  output logic [ID_W-1:0]   reply_id,
  output logic              mg_valid,
  output logic [ADDR_W-1:0] mg_line,
  input  logic              mg_merged,
  output logic              mq_push,
  output crd_req_t          mq_req,
  input  logic              mq_full,
  output logic [3:0]        ev
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  crd_req_t hold_q, hold_d;
  logic     hold_vld_q, hold_vld_d;
  logic     hit, retire, is_miss;
  crd_act_e act;

  assign hit = cfg_ideal | lk_hit;

  always_comb begin
    act = ACT_NONE;
    if (hold_vld_q) begin
      if (hit) begin
        if (!hold_q.wr) act = reply_ready ? ACT_RD_HIT : ACT_NONE;
        else            act = ACT_WR_HIT;
      end else if (!mq_full) begin
        act = mg_merged ? ACT_MISS_MERGE : ACT_MISS_SEND;
      end
    end
  end

  assign retire   = (act != ACT_NONE);
  assign is_miss  = (act == ACT_MISS_SEND) || (act == ACT_MISS_MERGE);
  assign src_take = src_valid & (~hold_vld_q | retire);

  assign lk_valid    = hold_vld_q;
  assign lk_addr     = hold_q.addr;
  assign lk_write    = hold_q.wr;
  assign reply_valid = hold_vld_q & hit & ~hold_q.wr;
  assign reply_addr  = hold_q.addr;
  assign reply_id    = hold_q.id;
  assign mg_valid    = is_miss;
  assign mg_line     = hold_q.addr & LINE_MASK;
  assign mq_push     = (act == ACT_MISS_SEND);

  always_comb begin
    mq_req = hold_q;
    if (hold_q.wr) mq_req.size = hold_q.size - SIZE_W'(RD_HDR);
  end

  assign ev[0] = (act == ACT_RD_HIT);
  assign ev[1] = (act == ACT_WR_HIT);
  assign ev[2] = is_miss & ~hold_q.wr;
  assign ev[3] = is_miss &  hold_q.wr;

  always_comb begin
    hold_vld_d = hold_vld_q;
    hold_d     = hold_q;
    if (src_take) begin
      hold_vld_d = 1'b1;
      hold_d     = src_req;
    end else if (retire) begin
      hold_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      hold_vld_q <= hold_vld_d;
      hold_q     <= hold_d;
    end
  end

  AST_REPLY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid && !reply_ready |=> reply_valid && $stable(reply_addr)); // R3
  AST_MISS_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !hit && mq_full |=> lk_valid && $stable(lk_addr)); // R5
  AST_MERGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mg_valid && !src_take |=> !mg_valid); // R6
endmodule

// File: rtl/crd_dram_arb.sv
module crd_dram_arb
  import crd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dram_full,
  input  logic              wb_valid,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [SIZE_W-1:0] wb_size,
  output logic              wb_ready,
  input  logic              mq_valid,
  input  crd_req_t          mq_req,
  output logic              mq_pop,
  output logic              dram_valid,
  output crd_req_t          dram_req,
  output logic              dram_is_wb
);
  crd_req_t wb_req;

  always_comb begin
    wb_req      = '0;
    wb_req.addr = wb_addr;
    wb_req.size = wb_size;
    wb_req.wr   = 1'b1;
  end

  assign wb_ready   = ~dram_full & wb_valid;
  assign mq_pop     = ~dram_full & ~wb_valid & mq_valid;
  assign dram_valid = wb_ready | mq_pop;
  assign dram_is_wb = wb_valid;
  assign dram_req   = wb_valid ? wb_req : mq_req;

  AST_WB_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr)); // R8
endmodule

// File: rtl/crd_sat_cnt.sv
module crd_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  assign en    = inc & ~(&cnt_q);
  assign cnt_d = cnt_q + 1'b1;
  assign cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> cnt_q >= $past(cnt_q)); // R10
  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/cache_req_dispatch.sv
module cache_req_dispatch
  import crd_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned RD_HDR     = 8,
  parameter int unsigned IN_DEPTH   = 4,
  parameter int unsigned MQ_DEPTH   = 4,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split_wr,
  input  logic              cfg_ideal,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [ID_W-1:0]   in_id,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              lk_write,
  input  logic              lk_hit,
  output logic              reply_valid,
  input  logic              reply_ready,
  output logic [ADDR_W-1:0] reply_addr,
  output logic [ID_W-1:0]   reply_id,
  output logic              mg_valid,
  output logic [ADDR_W-1:0] mg_line,
  input  logic              mg_merged,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [SIZE_W-1:0] wb_size,
  input  logic              dram_full,
  output logic              dram_valid,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_write,
  output logic [SIZE_W-1:0] dram_size,
  output logic [ID_W-1:0]   dram_id,
  output logic              dram_is_wb,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_miss
);
  localparam int unsigned N_EV = 4;

  crd_req_t         in_req, src_req, mq_in, mq_out, dram_req;
  logic             src_valid, src_take;
  logic             mq_push, mq_pop, mq_full, mq_empty;
  logic [N_EV-1:0]  ev;
  logic [CNT_W-1:0] cnt_arr [N_EV];

  always_comb begin
    in_req.addr = in_addr;
    in_req.wr   = in_write;
    in_req.size = in_size;
    in_req.id   = in_id;
  end

  crd_ingress #(.DEPTH(IN_DEPTH)) u_ingress (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_split_wr (cfg_split_wr),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_req       (in_req),
    .src_valid    (src_valid),
    .src_req      (src_req),
    .src_take     (src_take)
  );

  crd_req_engine #(.LINE_BYTES(LINE_BYTES), .RD_HDR(RD_HDR)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ideal   (cfg_ideal),
    .src_valid   (src_valid),
    .src_req     (src_req),
    .src_take    (src_take),
    .lk_valid    (lk_valid),
    .lk_addr     (lk_addr),
    .lk_write    (lk_write),
    .lk_hit      (lk_hit),
    .reply_valid (reply_valid),
    .reply_ready (reply_ready),
    .reply_addr  (reply_addr),
    .reply_id    (reply_id),
    .mg_valid    (mg_valid),
    .mg_line     (mg_line),
    .mg_merged   (mg_merged),
    .mq_push     (mq_push),
    .mq_req      (mq_in),
    .mq_full     (mq_full),
    .ev          (ev)
  );

  crd_fifo #(.WIDTH(REQ_W), .DEPTH(MQ_DEPTH)) u_miss_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (mq_push),
    .din   (mq_in),
    .full  (mq_full),
    .pop   (mq_pop),
    .dout  (mq_out),
    .empty (mq_empty)
  );

  crd_dram_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_full  (dram_full),
    .wb_valid   (wb_valid),
    .wb_addr    (wb_addr),
    .wb_size    (wb_size),
    .wb_ready   (wb_ready),
    .mq_valid   (~mq_empty),
    .mq_req     (mq_out),
    .mq_pop     (mq_pop),
    .dram_valid (dram_valid),
    .dram_req   (dram_req),
    .dram_is_wb (dram_is_wb)
  );

  assign dram_addr  = dram_req.addr;
  assign dram_write = dram_req.wr;
  assign dram_size  = dram_req.size;
  assign dram_id    = dram_req.id;

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    crd_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev[g]),
      .cnt   (cnt_arr[g])
    );
  end

  assign cnt_rd_hit  = cnt_arr[0];
  assign cnt_wr_hit  = cnt_arr[1];
  assign cnt_rd_miss = cnt_arr[2];
  assign cnt_wr_miss = cnt_arr[3];
endmodule

// File: tb/cache_req_dispatch_tb.sv
module cache_req_dispatch_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_split_wr = 1'b0, cfg_ideal = 1'b0;
  logic        in_valid = 1'b0, in_write = 1'b0;
  logic [31:0] in_addr = '0;
  logic [7:0]  in_size = '0;
  logic [5:0]  in_id = '0;
  logic        in_ready, lk_valid, lk_write, lk_hit;
  logic [31:0] lk_addr, reply_addr, mg_line, dram_addr;
  logic        reply_valid, reply_ready = 1'b1;
  logic [5:0]  reply_id, dram_id;
  logic        mg_valid, mg_merged;
  logic        wb_valid = 1'b0, wb_ready;
  logic [31:0] wb_addr = '0;
  logic [7:0]  wb_size = '0, dram_size;
  logic        dram_full = 1'b0, dram_valid, dram_write, dram_is_wb;
  logic [31:0] cnt_rd_hit, cnt_wr_hit, cnt_rd_miss, cnt_wr_miss;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tag array model: hit when address bit 8 is set; merge table: merged when line bit 9 is set
  assign lk_hit    = lk_addr[8];
  assign mg_merged = mg_line[9];

  cache_req_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_split_wr(cfg_split_wr), .cfg_ideal(cfg_ideal),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_write(in_write),
    .in_size(in_size), .in_id(in_id),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write), .lk_hit(lk_hit),
    .reply_valid(reply_valid), .reply_ready(reply_ready), .reply_addr(reply_addr),
    .reply_id(reply_id), .mg_valid(mg_valid), .mg_line(mg_line), .mg_merged(mg_merged),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_size(wb_size),
    .dram_full(dram_full), .dram_valid(dram_valid), .dram_addr(dram_addr),
    .dram_write(dram_write), .dram_size(dram_size), .dram_id(dram_id),
    .dram_is_wb(dram_is_wb), .cnt_rd_hit(cnt_rd_hit), .cnt_wr_hit(cnt_wr_hit),
    .cnt_rd_miss(cnt_rd_miss), .cnt_wr_miss(cnt_wr_miss)
  );

  int n_chk = 0, n_fail = 0;
  int n_iss = 0, n_rep = 0;
  logic [31:0] last_d_addr, last_r_addr;
  logic [7:0]  last_d_size;
  logic        last_d_wr;
  bit          done = 1'b0;

  always @(posedge clk) begin
    if (rst_n && dram_valid) begin
      n_iss++; last_d_addr = dram_addr; last_d_size = dram_size; last_d_wr = dram_write;
    end
    if (rst_n && reply_valid && reply_ready) begin
      n_rep++; last_r_addr = reply_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [7:0] s, input logic [5:0] id);
    @(negedge clk);
    in_addr = a; in_write = w; in_size = s; in_id = id; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // vector: addr[27:12] wr[11] size[10:3] kind[2:0]
  // kind 0 rd hit, 1 wr hit, 2 rd miss sent, 3 wr miss sent, 4 rd merged, 5 wr merged
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {16'h0140, 1'b0, 8'd4,  3'd0},
    {16'h0180, 1'b1, 8'd36, 3'd1},
    {16'h0040, 1'b0, 8'd4,  3'd2},
    {16'h0080, 1'b1, 8'd40, 3'd3},
    {16'h0200, 1'b0, 8'd4,  3'd4},
    {16'h0240, 1'b1, 8'd20, 3'd5},
    {16'h10C4, 1'b0, 8'd16, 3'd2},
    {16'h0C00, 1'b1, 8'd8,  3'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] b_rh, b_wh, b_rm, b_wm;
    int b_iss, b_rep;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cnt_rd_hit == 0 && cnt_wr_hit == 0 && cnt_rd_miss == 0 && cnt_wr_miss == 0,
        "R10 counters zero after reset", cnt_rd_hit | cnt_wr_miss, 0);
    chk(in_ready && !lk_valid && !dram_valid && !reply_valid, "R10 queues empty after reset",
        {in_ready, lk_valid, dram_valid, reply_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a; logic w; logic [7:0] s; int k;
      a = {16'h0, VEC[i][27:12]}; w = VEC[i][11]; s = VEC[i][10:3]; k = int'(VEC[i][2:0]);
      b_rh = cnt_rd_hit; b_wh = cnt_wr_hit; b_rm = cnt_rd_miss; b_wm = cnt_wr_miss;
      b_iss = n_iss; b_rep = n_rep;
      push(a, w, s, 6'(i));
      repeat (6) @(negedge clk);
      chk({cnt_rd_hit - b_rh, cnt_wr_hit - b_wh, cnt_rd_miss - b_rm, cnt_wr_miss - b_wm} ==
          {32'(k == 0), 32'(k == 1), 32'(k == 2 || k == 4), 32'(k == 3 || k == 5)},
          "R3 R4 R5 counter deltas", cnt_rd_hit - b_rh, 32'(k == 0));
      chk(n_rep - b_rep == ((k == 0) ? 1 : 0), "R3 R4 reply count", n_rep - b_rep, (k == 0));
      chk(n_iss - b_iss == ((k == 2 || k == 3) ? 1 : 0), "R6 DRAM sends only unmerged misses",
          n_iss - b_iss, (k == 2 || k == 3));
      if (k == 0) chk(last_r_addr == a, "R3 reply address", last_r_addr, a);
      if (k == 2 || k == 3)
        chk(last_d_addr == a && last_d_wr == w && last_d_size == (w ? s - 8'd8 : s),
            "R7 DRAM payload", {last_d_addr, last_d_wr, last_d_size}, {a, w, w ? s - 8'd8 : s});
    end

    // R3 reply back-pressure
    reply_ready = 1'b0;
    b_rh = cnt_rd_hit; b_rep = n_rep;
    push(32'h0100, 1'b0, 8'd4, 6'd9);
    repeat (4) @(negedge clk);
    chk(reply_valid && reply_addr == 32'h0100 && cnt_rd_hit == b_rh, "R3 read hit held while reply full",
        {reply_valid, cnt_rd_hit - b_rh}, {1'b1, 32'd0});
    reply_ready = 1'b1;
    @(negedge clk);
    chk(cnt_rd_hit == b_rh + 1 && !reply_valid && n_rep == b_rep + 1, "R3 retire once reply ready",
        cnt_rd_hit - b_rh, 1);

    // R2 main queue before write queue
    cfg_split_wr = 1'b1; reply_ready = 1'b0;
    push(32'h0100, 1'b0, 8'd4, 6'd1);
    push(32'h0180, 1'b1, 8'd16, 6'd2);
    push(32'h0140, 1'b0, 8'd4, 6'd3);
    repeat (2) @(negedge clk);
    reply_ready = 1'b1;
    @(negedge clk);
    chk(lk_valid && !lk_write && lk_addr == 32'h0140, "R2 main queue served before write queue",
        lk_addr, 32'h0140);
    repeat (6) @(negedge clk);

    // R1 no split: arrival order
    cfg_split_wr = 1'b0; reply_ready = 1'b0;
    push(32'h0100, 1'b0, 8'd4, 6'd1);
    push(32'h0180, 1'b1, 8'd16, 6'd2);
    push(32'h0140, 1'b0, 8'd4, 6'd3);
    repeat (2) @(negedge clk);
    reply_ready = 1'b1;
    @(negedge clk);
    chk(lk_valid && lk_write && lk_addr == 32'h0180, "R1 write kept in main queue order",
        lk_addr, 32'h0180);
    repeat (6) @(negedge clk);

    // R5 / R8 miss queue full and DRAM arbitration
    dram_full = 1'b1;
    b_rm = cnt_rd_miss; b_iss = n_iss;
    push(32'h0000, 1'b0, 8'd4, 6'd1);
    push(32'h0040, 1'b0, 8'd4, 6'd2);
    push(32'h0400, 1'b0, 8'd4, 6'd3);
    push(32'h0440, 1'b0, 8'd4, 6'd4);
    push(32'h0800, 1'b0, 8'd4, 6'd5);
    repeat (4) @(negedge clk);
    chk(cnt_rd_miss - b_rm == 4, "R5 miss not counted while miss queue full", cnt_rd_miss - b_rm, 4);
    chk(lk_valid && lk_addr == 32'h0800, "R5 miss retried in place", lk_addr, 32'h0800);
    wb_valid = 1'b1; wb_addr = 32'hABC0; wb_size = 8'd64;
    #1;
    chk(!dram_valid && !wb_ready && n_iss == b_iss, "R8 nothing issued while scheduler full",
        {dram_valid, wb_ready}, 2'b00);
    @(negedge clk);
    dram_full = 1'b0;
    #1;
    chk(dram_valid && dram_is_wb && dram_write && dram_addr == 32'hABC0 && dram_size == 8'd64,
        "R8 writeback issued before queued misses", dram_addr, 32'hABC0);
    @(negedge clk);
    wb_valid = 1'b0;
    #1;
    chk(dram_valid && !dram_is_wb && dram_addr == 32'h0000, "R8 oldest miss issued after writeback",
        dram_addr, 32'h0000);
    repeat (10) @(negedge clk);
    chk(n_iss - b_iss == 6 && cnt_rd_miss - b_rm == 5, "R5 all misses drained",
        n_iss - b_iss, 6);

    // R9 ideal mode
    cfg_ideal = 1'b1;
    b_rh = cnt_rd_hit; b_wh = cnt_wr_hit; b_iss = n_iss; b_rep = n_rep;
    push(32'h0040, 1'b0, 8'd4, 6'd7);
    push(32'h0080, 1'b1, 8'd12, 6'd8);
    repeat (6) @(negedge clk);
    chk(cnt_rd_hit - b_rh == 1 && cnt_wr_hit - b_wh == 1 && n_rep - b_rep == 1,
        "R9 ideal mode treats misses as hits", cnt_rd_hit - b_rh, 1);
    chk(n_iss == b_iss, "R9 ideal mode sends nothing to DRAM", n_iss - b_iss, 0);
    cfg_ideal = 1'b0;

    // R10 reset clears counters
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cnt_rd_hit == 0 && cnt_wr_hit == 0 && cnt_rd_miss == 0 && cnt_wr_miss == 0,
        "R10 reset clears counters", cnt_rd_miss, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule